// File: doc/BRIEF.md
# Decimating Filter Configuration Write Port

This block sits between a host control bus and a two-stage decimating filter (an integrate-and-comb front stage followed by a multiply-accumulate FIR). A host places a 16-bit word on the bus, picks one of four register slots with a 2-bit selector, pulls the active-low select low and pulses the active-low write strobe. The word lands when the strobe returns high. The strobe is sampled in the system clock domain, so the write takes effect on the first clock edge that sees it high after having seen it low.

Three of the slots hold plain control words. The block decodes them into named fields for the FIR stage and the comb stage. The fourth slot is a coefficient port. Two consecutive writes build one 20-bit coefficient, which is stored in a coefficient memory at a pointer that advances by one per finished coefficient. The pointer and the half-word phase return to zero on reset. They also return to zero when the host writes the FIR-off bit. A start pulse from the filter's start logic takes the FIR out of the off state. Reset clears only a chosen subset of fields and leaves every other field and the memory contents alone.

Top module: `filt_cfg_port`

## Requirements
- R1: A write happens only on a clock edge where the strobe is sampled high after being low on the previous edge with the select low. A strobe cycle with the select high, or a strobe that is still held low, changes no field.
- R2: Selector 0 loads these fields: bit 15 zero one pre-adder input, bit 14 FIR bypass, bit 13 even symmetry, bits 12:9 FIR decimation minus one, bits 8:0 tap count minus one.
- R3: The tap-count-minus-one output never reads below 2. A stored value of 0 or 1 is presented as 2, and larger values pass through unchanged.
- R4: Selector 2 loads bit 12 FIR off, bit 11 accumulator clear, bit 10 comb-stage bypass and bits 9:0 comb decimation minus one. Bits 15:13 are ignored.
- R5: Selector 3 loads bits 8:3 growth value and bits 2:0 stage count. Bits 15:9 are ignored.
- R6: Selector 1 takes coefficient bits 19:4 on the first write. On the second write it takes bits 3:0 from data bits 3:0 and ignores data bits 15:4. The memory is written only when the second half arrives, at the current pointer, and the pointer then advances by one.
- R7: After the last memory location is written, the pointer wraps to location 0.
- R8: Reset sets FIR off, clears FIR bypass, stage count and comb decimation, and rewinds the pointer and half-word phase. It leaves all other fields and the memory contents unchanged.
- R9: A selector-2 write with bit 12 set rewinds the pointer and the half-word phase, so a pending first half is discarded.
- R10: A start pulse clears FIR off on the next edge. If a selector-2 write happens on the same edge, the written bit 12 takes effect instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cbus | input | 16 | Control bus data |
| reg_sel | input | 2 | Register slot selector |
| sel_n | input | 1 | Active-low select |
| wstb_n | input | 1 | Active-low write strobe, acts on its rising edge |
| start_pulse | input | 1 | One-cycle start event from the start logic |
| coef_rd_idx | input | 8 | Coefficient memory read index |
| coef_rd_val | output | 20 | Coefficient at the read index |
| zero_pre | output | 1 | Zero one pre-adder input |
| fir_byp | output | 1 | FIR bypass |
| sym_even | output | 1 | Even symmetry (1) or odd (0) |
| fir_dec_m1 | output | 4 | FIR decimation minus one |
| taps_m1 | output | 9 | Tap count minus one, floored at 2 |
| fir_off | output | 1 | FIR halted for reprogramming |
| acc_clr | output | 1 | Accumulator feedback cleared |
| cic_byp | output | 1 | Comb stage bypass |
| cic_dec_m1 | output | 10 | Comb decimation minus one |
| growth_sel | output | 6 | Growth (shifter position) value |
| cic_order | output | 3 | Comb stage count |

## Verification
Two things can hit the FIR-off bit on the same clock edge: a start pulse, which clears it, and a selector-2 write, which loads it. The bench raises the start pulse in the very cycle the strobe returns high on a selector-2 write. It does this once with bit 12 set and once with it clear, and expects the written value each time. The pointer rewind from the bit-12 write can also land on a half-finished coefficient. That case is judged by reading back where the next complete coefficient is stored.

// File: rtl/filt_cfg_pkg.sv
// Shared constants for the filter configuration write port.
// Assumes a 16-bit control bus; field positions are fixed by the decoder map.
package filt_cfg_pkg;

    localparam int CBUS_W = 16;
    localparam int SEL_W  = 2;

    // Register slots decoded from the selector.
    typedef enum logic [SEL_W-1:0] {
        SLOT_FIR   = 2'd0,
        SLOT_COEF  = 2'd1,
        SLOT_CIC   = 2'd2,
        SLOT_SHAPE = 2'd3
    } slot_e;

    // FIR configuration slot.
    localparam int FIR_ZPRE_BIT = 15;
    localparam int FIR_BYP_BIT  = 14;
    localparam int FIR_SYM_BIT  = 13;
    localparam int FIR_DEC_LSB  = 9;
    localparam int FIR_DEC_W    = 4;
    localparam int TAPS_LSB     = 0;
    localparam int TAPS_W       = 9;

    // Comb-stage control slot.
    localparam int CIC_OFF_BIT  = 12;
    localparam int CIC_CLR_BIT  = 11;
    localparam int CIC_BYP_BIT  = 10;
    localparam int CIC_DEC_LSB  = 0;
    localparam int CIC_DEC_W    = 10;

    // Shape slot.
    localparam int GROW_LSB     = 3;
    localparam int GROW_W       = 6;
    localparam int ORDER_LSB    = 0;
    localparam int ORDER_W      = 3;

endpackage

// File: rtl/filt_cfg_wr_sense.sv
// Turns the host write strobe into a single-cycle write event.
// Assumes strobe and select are already synchronous to clk; the event fires
// on the first edge that sees the strobe high after seeing it low.
module filt_cfg_wr_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic wstb_n,
    input  logic sel_n,
    output logic wr_evt
);

    logic wstb_q;

    // Remember the strobe level from the previous edge; idle is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wstb_q <= 1'b1;
        end else begin
            wstb_q <= wstb_n;
        end
    end

    // Rising strobe with select held low marks a write.
    always_comb begin
        wr_evt = rst_n && !wstb_q && wstb_n && !sel_n;
    end

endmodule

// File: rtl/filt_cfg_bank.sv
// Holds the three plain control slots and decodes their fields.
// Assumes at most one write event per cycle; only FIR off, FIR bypass,
// comb decimation and stage count respond to reset.
module filt_cfg_bank
    import filt_cfg_pkg::*;
#(
    parameter int MIN_TAPS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_evt,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [CBUS_W-1:0]    wr_data,
    input  logic                 start_pulse,
    output logic                 off_set,
    output logic                 zero_pre,
    output logic                 fir_byp,
    output logic                 sym_even,
    output logic [FIR_DEC_W-1:0] fir_dec_m1,
    output logic [TAPS_W-1:0]    taps_m1,
    output logic                 fir_off,
    output logic                 acc_clr,
    output logic                 cic_byp,
    output logic [CIC_DEC_W-1:0] cic_dec_m1,
    output logic [GROW_W-1:0]    growth_sel,
    output logic [ORDER_W-1:0]   cic_order
);

    localparam logic [TAPS_W-1:0] TAPS_FLOOR = TAPS_W'(MIN_TAPS - 1);

    logic              hit_fir;
    logic              hit_cic;
    logic              hit_shape;
    logic [TAPS_W-1:0] taps_raw;

    // Slot decode for the current write event.
    always_comb begin
        hit_fir   = wr_evt && (wr_sel == SLOT_FIR);
        hit_cic   = wr_evt && (wr_sel == SLOT_CIC);
        hit_shape = wr_evt && (wr_sel == SLOT_SHAPE);
        off_set   = hit_cic && wr_data[CIC_OFF_BIT];
    end

    // Fields with reset defaults; a same-edge write outranks a start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fir_off    <= 1'b1;
            fir_byp    <= 1'b0;
            cic_dec_m1 <= '0;
            cic_order  <= '0;
        end else begin
            if (start_pulse) begin
                fir_off <= 1'b0;
            end
            if (hit_fir) begin
                fir_byp <= wr_data[FIR_BYP_BIT];
            end
            if (hit_cic) begin
                fir_off    <= wr_data[CIC_OFF_BIT];
                cic_dec_m1 <= wr_data[CIC_DEC_LSB +: CIC_DEC_W];
            end
            if (hit_shape) begin
                cic_order <= wr_data[ORDER_LSB +: ORDER_W];
            end
        end
    end

    // Fields that keep their value through reset.
    always_ff @(posedge clk) begin
        if (hit_fir) begin
            zero_pre   <= wr_data[FIR_ZPRE_BIT];
            sym_even   <= wr_data[FIR_SYM_BIT];
            fir_dec_m1 <= wr_data[FIR_DEC_LSB +: FIR_DEC_W];
            taps_raw   <= wr_data[TAPS_LSB +: TAPS_W];
        end
        if (hit_cic) begin
            acc_clr <= wr_data[CIC_CLR_BIT];
            cic_byp <= wr_data[CIC_BYP_BIT];
        end
        if (hit_shape) begin
            growth_sel <= wr_data[GROW_LSB +: GROW_W];
        end
    end

    // Present the tap count with the minimum length enforced.
    always_comb begin
        taps_m1 = (taps_raw < TAPS_FLOOR) ? TAPS_FLOOR : taps_raw;
    end

endmodule

// File: rtl/filt_cfg_coef_store.sv
// Builds wide coefficients from two bus writes and stores them sequentially.
// Assumes COEF_W is wider than the bus; the low part arrives in the low bits
// of the second write. Memory contents are never reset.
module filt_cfg_coef_store
    import filt_cfg_pkg::*;
#(
    parameter int COEF_W     = 20,
    parameter int COEF_DEPTH = 256,
    localparam int PTR_W     = $clog2(COEF_DEPTH),
    localparam int LO_W      = COEF_W - CBUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [CBUS_W-1:0] wr_data,
    input  logic              rewind,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [COEF_W-1:0] rd_val,
    output logic [PTR_W-1:0]  ptr,
    output logic              phase
);

    logic [COEF_W-1:0] mem [COEF_DEPTH];
    logic [CBUS_W-1:0] hold_hi;
    logic              hit;
    logic              commit;
    logic [PTR_W-1:0]  ptr_nxt;

    // Coefficient slot decode and the completing half.
    always_comb begin
        hit     = wr_evt && (wr_sel == SLOT_COEF);
        commit  = hit && phase;
        ptr_nxt = (ptr == PTR_W'(COEF_DEPTH - 1)) ? '0 : ptr + 1'b1;
    end

    // Pointer and half-word phase, rewound by reset or by the FIR-off write.
    always_ff @(posedge clk) begin
        if (!rst_n || rewind) begin
            ptr   <= '0;
            phase <= 1'b0;
        end else if (hit) begin
            phase <= !phase;
            if (commit) begin
                ptr <= ptr_nxt;
            end
        end
    end

    // Capture the upper part of a coefficient from the first write.
    always_ff @(posedge clk) begin
        if (hit && !phase) begin
            hold_hi <= wr_data;
        end
    end

    // Store the finished coefficient; skipped while reset is held.
    always_ff @(posedge clk) begin
        if (rst_n && commit) begin
            mem[ptr] <= {hold_hi, wr_data[LO_W-1:0]};
        end
    end

    // Read port for inspection of stored coefficients.
    always_comb begin
        rd_val = mem[rd_idx];
    end

endmodule

// File: rtl/filt_cfg_port.sv
// Top of the filter configuration write port: strobe sensing, control slots
// and the coefficient store. Assumes all inputs are synchronous to clk.
module filt_cfg_port
    import filt_cfg_pkg::*;
#(
    parameter int COEF_W     = 20,
    parameter int COEF_DEPTH = 256,
    parameter int MIN_TAPS   = 3,
    localparam int PTR_W     = $clog2(COEF_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CBUS_W-1:0]    cbus,
    input  logic [SEL_W-1:0]     reg_sel,
    input  logic                 sel_n,
    input  logic                 wstb_n,
    input  logic                 start_pulse,
    input  logic [PTR_W-1:0]     coef_rd_idx,
    output logic [COEF_W-1:0]    coef_rd_val,
    output logic                 zero_pre,
    output logic                 fir_byp,
    output logic                 sym_even,
    output logic [FIR_DEC_W-1:0] fir_dec_m1,
    output logic [TAPS_W-1:0]    taps_m1,
    output logic                 fir_off,
    output logic                 acc_clr,
    output logic                 cic_byp,
    output logic [CIC_DEC_W-1:0] cic_dec_m1,
    output logic [GROW_W-1:0]    growth_sel,
    output logic [ORDER_W-1:0]   cic_order
);

    logic             wr_evt;
    logic             off_set;
    logic [PTR_W-1:0] coef_ptr;
    logic             coef_phase;

    filt_cfg_wr_sense i_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .wstb_n (wstb_n),
        .sel_n  (sel_n),
        .wr_evt (wr_evt)
    );

    filt_cfg_bank #(
        .MIN_TAPS (MIN_TAPS)
    ) i_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_evt      (wr_evt),
        .wr_sel      (reg_sel),
        .wr_data     (cbus),
        .start_pulse (start_pulse),
        .off_set     (off_set),
        .zero_pre    (zero_pre),
        .fir_byp     (fir_byp),
        .sym_even    (sym_even),
        .fir_dec_m1  (fir_dec_m1),
        .taps_m1     (taps_m1),
        .fir_off     (fir_off),
        .acc_clr     (acc_clr),
        .cic_byp     (cic_byp),
        .cic_dec_m1  (cic_dec_m1),
        .growth_sel  (growth_sel),
        .cic_order   (cic_order)
    );

    filt_cfg_coef_store #(
        .COEF_W     (COEF_W),
        .COEF_DEPTH (COEF_DEPTH)
    ) i_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_evt  (wr_evt),
        .wr_sel  (reg_sel),
        .wr_data (cbus),
        .rewind  (off_set),
        .rd_idx  (coef_rd_idx),
        .rd_val  (coef_rd_val),
        .ptr     (coef_ptr),
        .phase   (coef_phase)
    );

endmodule

// File: rtl/filt_cfg_port_chk.sv
// Property checker for the configuration write port, bound to the top.
module filt_cfg_port_chk
    import filt_cfg_pkg::*;
#(
    parameter int COEF_DEPTH = 256,
    localparam int PTR_W     = $clog2(COEF_DEPTH)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_evt,
    input logic [SEL_W-1:0]     reg_sel,
    input logic [CBUS_W-1:0]    cbus,
    input logic                 start_pulse,
    input logic                 zero_pre,
    input logic                 fir_byp,
    input logic                 sym_even,
    input logic [FIR_DEC_W-1:0] fir_dec_m1,
    input logic [TAPS_W-1:0]    taps_m1,
    input logic                 fir_off,
    input logic                 acc_clr,
    input logic                 cic_byp,
    input logic [CIC_DEC_W-1:0] cic_dec_m1,
    input logic [GROW_W-1:0]    growth_sel,
    input logic [ORDER_W-1:0]   cic_order,
    input logic [PTR_W-1:0]     coef_ptr,
    input logic                 coef_phase
);

    // R1
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_evt |=> $stable({zero_pre, fir_byp, sym_even, fir_dec_m1, taps_m1,
                             acc_clr, cic_byp, cic_dec_m1, growth_sel, cic_order}));

    // R3
    taps_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taps_m1 >= TAPS_W'(2));

    // R6
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && reg_sel == SLOT_COEF && coef_phase) |=>
            (coef_ptr == PTR_W'((int'($past(coef_ptr)) + 1) % COEF_DEPTH)) && !coef_phase);

    // R8
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fir_off && !fir_byp && cic_order == '0 && cic_dec_m1 == '0
                          && coef_ptr == '0 && !coef_phase));

    // R9
    off_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && reg_sel == SLOT_CIC && cbus[CIC_OFF_BIT]) |=>
            (coef_ptr == '0 && !coef_phase && fir_off));

    // R10
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && !(wr_evt && reg_sel == SLOT_CIC)) |=> !fir_off);

endmodule

bind filt_cfg_port filt_cfg_port_chk #(
    .COEF_DEPTH (COEF_DEPTH)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_evt      (wr_evt),
    .reg_sel     (reg_sel),
    .cbus        (cbus),
    .start_pulse (start_pulse),
    .zero_pre    (zero_pre),
    .fir_byp     (fir_byp),
    .sym_even    (sym_even),
    .fir_dec_m1  (fir_dec_m1),
    .taps_m1     (taps_m1),
    .fir_off     (fir_off),
    .acc_clr     (acc_clr),
    .cic_byp     (cic_byp),
    .cic_dec_m1  (cic_dec_m1),
    .growth_sel  (growth_sel),
    .cic_order   (cic_order),
    .coef_ptr    (coef_ptr),
    .coef_phase  (coef_phase)
);

// File: tb/test_filt_cfg_port.sv
module test_filt_cfg_port;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cbus = '0;
    logic [1:0]  reg_sel = '0;
    logic        sel_n = 1'b1;
    logic        wstb_n = 1'b1;
    logic        start_pulse = 1'b0;
    logic [7:0]  coef_rd_idx = '0;
    logic [19:0] coef_rd_val;
    logic        zero_pre, fir_byp, sym_even, fir_off, acc_clr, cic_byp;
    logic [3:0]  fir_dec_m1;
    logic [8:0]  taps_m1;
    logic [9:0]  cic_dec_m1;
    logic [5:0]  growth_sel;
    logic [2:0]  cic_order;

    filt_cfg_port i_filt_cfg_port (
        .clk(clk), .rst_n(rst_n), .cbus(cbus), .reg_sel(reg_sel), .sel_n(sel_n),
        .wstb_n(wstb_n), .start_pulse(start_pulse), .coef_rd_idx(coef_rd_idx),
        .coef_rd_val(coef_rd_val), .zero_pre(zero_pre), .fir_byp(fir_byp),
        .sym_even(sym_even), .fir_dec_m1(fir_dec_m1), .taps_m1(taps_m1),
        .fir_off(fir_off), .acc_clr(acc_clr), .cic_byp(cic_byp),
        .cic_dec_m1(cic_dec_m1), .growth_sel(growth_sel), .cic_order(cic_order)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural model state
    int m_zpre, m_fbyp, m_sym, m_fdec, m_taps, m_off, m_clr, m_cbyp, m_cdec, m_grow, m_ord;
    int m_coef [DEPTH];
    int m_ptr, m_ph, m_hold;
    int n_chk = 0, n_fail = 0;
    bit cmp_on = 0, done = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void model_write(int a, int d);
        case (a)
            0: begin
                m_zpre = (d >> 15) & 1; m_fbyp = (d >> 14) & 1; m_sym = (d >> 13) & 1;
                m_fdec = (d >> 9) & 15; m_taps = d & 511;
            end
            1: begin
                if (m_ph == 0) begin
                    m_hold = d & 16'hFFFF; m_ph = 1;
                end else begin
                    m_coef[m_ptr] = (m_hold << 4) | (d & 15);
                    m_ptr = (m_ptr + 1) % DEPTH; m_ph = 0;
                end
            end
            2: begin
                m_off = (d >> 12) & 1; m_clr = (d >> 11) & 1; m_cbyp = (d >> 10) & 1;
                m_cdec = d & 1023;
                if (m_off == 1) begin m_ptr = 0; m_ph = 0; end
            end
            default: begin
                m_grow = (d >> 3) & 63; m_ord = d & 7;
            end
        endcase
    endfunction

    // One host write; optional start pulse on the same edge; optional no-select.
    task automatic bus_wr(int a, int d, bit with_start = 0, bit cs = 1);
        @(negedge clk);
        sel_n = !cs; reg_sel = 2'(a); cbus = 16'(d); wstb_n = 1'b0;
        @(negedge clk);
        wstb_n = 1'b1;
        if (with_start) start_pulse = 1'b1;
        @(negedge clk);
        start_pulse = 1'b0; sel_n = 1'b1;
        if (with_start) m_off = 0;
        if (cs) model_write(a, d);
    endtask

    task automatic coef_wr(int val, int junk = 0);
        bus_wr(1, (val >> 4) & 16'hFFFF);
        bus_wr(1, (junk << 4) | (val & 15));
    endtask

    task automatic pulse_start();
        @(negedge clk); start_pulse = 1'b1;
        @(negedge clk); start_pulse = 1'b0; m_off = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_off = 1; m_fbyp = 0; m_ord = 0; m_cdec = 0; m_ptr = 0; m_ph = 0;
    endtask

    task automatic chk_coef(string req, int idx);
        @(negedge clk); coef_rd_idx = 8'(idx); #1;
        chk(req, $sformatf("coef[%0d]", idx), int'(coef_rd_val), m_coef[idx]);
    endtask

    // Per-cycle comparison of every decoded field against the model.
    always @(negedge clk) begin
        #(CLK_PERIOD / 4);
        if (cmp_on && rst_n) begin
            chk("R2", "zero_pre", int'(zero_pre), m_zpre);
            chk("R2", "fir_byp", int'(fir_byp), m_fbyp);
            chk("R2", "sym_even", int'(sym_even), m_sym);
            chk("R2", "fir_dec_m1", int'(fir_dec_m1), m_fdec);
            chk("R3", "taps_m1", int'(taps_m1), (m_taps < 2) ? 2 : m_taps);
            chk("R10", "fir_off", int'(fir_off), m_off);
            chk("R4", "acc_clr", int'(acc_clr), m_clr);
            chk("R4", "cic_byp", int'(cic_byp), m_cbyp);
            chk("R4", "cic_dec_m1", int'(cic_dec_m1), m_cdec);
            chk("R5", "growth_sel", int'(growth_sel), m_grow);
            chk("R5", "cic_order", int'(cic_order), m_ord);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_zpre = 0; m_fbyp = 0; m_sym = 0; m_fdec = 0; m_taps = 0; m_off = 1; m_clr = 0;
        m_cbyp = 0; m_cdec = 0; m_grow = 0; m_ord = 0; m_ptr = 0; m_ph = 0; m_hold = 0;
        for (int i = 0; i < DEPTH; i++) m_coef[i] = 0;
        repeat (3) @(negedge clk);
        do_reset();
        // R8 reset state
        chk("R8", "fir_off after reset", int'(fir_off), 1);
        chk("R8", "fir_byp after reset", int'(fir_byp), 0);
        chk("R8", "cic_order after reset", int'(cic_order), 0);
        chk("R8", "cic_dec_m1 after reset", int'(cic_dec_m1), 0);

        // R2 R4 R5 field decode under distinct patterns
        bus_wr(0, 16'hA5C3);
        bus_wr(2, 16'hE5A7);
        bus_wr(3, 16'hFFFF);
        cmp_on = 1;
        bus_wr(0, 16'h5A3C);
        bus_wr(2, 16'h0B5A);
        bus_wr(3, 16'h01AD);

        // R1: select high ignored; held-low strobe does nothing until release
        bus_wr(0, 16'hFFFF, 0, 0);
        bus_wr(3, 16'h0000, 0, 0);
        chk("R1", "growth unchanged with select high", int'(growth_sel), m_grow);
        @(negedge clk); sel_n = 0; reg_sel = 2'd3; cbus = 16'h0007; wstb_n = 0;
        repeat (3) @(negedge clk);
        chk("R1", "order unchanged while strobe low", int'(cic_order), m_ord);
        wstb_n = 1; @(negedge clk); sel_n = 1; model_write(3, 16'h0007);
        chk("R1", "order after strobe release", int'(cic_order), 7);

        // R3 tap floor
        bus_wr(0, 16'h0000);
        chk("R3", "taps from 0", int'(taps_m1), 2);
        bus_wr(0, 16'h0001);
        chk("R3", "taps from 1", int'(taps_m1), 2);
        bus_wr(0, 16'h01FE);
        chk("R3", "taps 510", int'(taps_m1), 510);

        // R6 coefficient assembly, junk in upper bits of second write
        bus_wr(2, 16'h1000);          // rewind pointer first
        coef_wr(20'hABCDE, 12'hFFF);
        coef_wr(20'h12345, 12'h5A5);
        coef_wr(20'hFEDC1, 12'h000);
        chk_coef("R6", 0); chk_coef("R6", 1); chk_coef("R6", 2);

        // R9: pending half discarded by an off write
        bus_wr(1, 16'h7777);
        bus_wr(2, 16'h1003);
        coef_wr(20'h0F0F0);
        chk_coef("R9", 0); chk_coef("R9", 1);

        // R10: start alone, then start colliding with off writes
        pulse_start();
        chk("R10", "off cleared by start", int'(fir_off), 0);
        bus_wr(2, 16'h1000, 1);
        chk("R10", "write 1 wins over start", int'(fir_off), 1);
        bus_wr(2, 16'h0000, 1);
        chk("R10", "write 0 with start", int'(fir_off), 0);
        bus_wr(2, 16'h1000);

        // R8: reset keeps other fields and memory, rewinds pending half
        bus_wr(0, 16'hE7FF);
        bus_wr(2, 16'h0FFF);
        bus_wr(3, 16'h01FF);
        coef_wr(20'h11111);
        bus_wr(1, 16'h9999);
        do_reset();
        chk("R8", "zero_pre kept", int'(zero_pre), 1);
        chk("R8", "growth kept", int'(growth_sel), 63);
        chk("R8", "fir_off set", int'(fir_off), 1);
        chk_coef("R8", 1);
        coef_wr(20'h2468A);
        chk_coef("R8", 0); chk_coef("R8", 1);

        // R7 pointer wrap
        do_reset();
        for (int i = 0; i < DEPTH; i++) coef_wr((i * 20'h01357 + 20'h00ABC) & 20'hFFFFF, i);
        chk_coef("R7", 0); chk_coef("R7", 128); chk_coef("R7", DEPTH - 1);
        coef_wr(20'hC0FFE);
        chk_coef("R7", 0); chk_coef("R7", 1);

        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule